// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Sequencer

This block frees an I2C bus that a slave has left hung, most often by holding SDA low partway through a byte. When asked to recover, it first lets go of both lines and waits one phase for them to settle. It then loops. In each pass it samples the bus, and the bus counts as free only when SCL and SDA both read high. If the bus is not free, the block sends one SCL pulse: SCL is driven low for one phase and then released for one phase. A stuck slave can clock out its remaining bits this way and let go of SDA.

The loop stops at the first free-bus sample, which reports success, or when the pulse budget is spent, which reports failure. The block never drives SDA. For the whole sequence it asserts a reset-hold output, so the main transfer controller stays in soft reset and cannot fight over the lines. The bus inputs pass through a synchronizer before they are sampled. The phase length in clock ticks and the pulse budget are parameters.

Top module: `i2c_bus_recover`

## Requirements
- R1: After reset, scl_oe_o, sda_oe_o, busy_o, core_rst_o, recovered_o and failed_o are all 0.
- R2: A start_i pulse while idle makes busy_o rise on the next clock, with both line drivers released. If the bus then reads free, recovered_o is set without any SCL pulse.
- R3: sda_oe_o is never 1.
- R4: When the bus is not free at a check, exactly one SCL low pulse follows before the next check. A bus that frees after k pulses therefore ends with recovered_o = 1 after exactly k pulses.
- R5: If the bus never frees, exactly MAX_TRIES SCL pulses are issued, and then failed_o = 1 and recovered_o = 0.
- R6: Each SCL low phase (scl_oe_o = 1) lasts exactly HALF_TICKS clock cycles. Each release after a pulse lasts at least HALF_TICKS cycles before the next pulse.
- R7: core_rst_o equals 1 in every cycle that busy_o is 1, and 0 when busy_o is 0.
- R8: The bus counts as free only when SCL and SDA both read high. A bus with SCL held low and SDA high is not free and gets pulses.
- R9: start_i has no effect while busy. A new start while idle clears recovered_o and failed_o on the next clock. recovered_o and failed_o are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a recovery sequence (sampled while idle) |
| scl_i | input | 1 | Sensed SCL level (asynchronous) |
| sda_i | input | 1 | Sensed SDA level (asynchronous) |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low; held at 0 |
| core_rst_o | output | 1 | Holds the transfer core in soft reset |
| busy_o | output | 1 | Sequence in progress |
| recovered_o | output | 1 | Last sequence ended with a free bus |
| failed_o | output | 1 | Last sequence spent its pulse budget |

## Verification
The sequence runs against a modelled slave in four situations. A bus that is already free shows that the check comes before any pulse. An SDA that lets go after three pulses shows that the number of pulses matches what the slave needs. A slave that holds SCL low for two pulses shows that SDA high alone is not enough for a free bus. A slave that never lets go shows that the pulse budget is exact and that the run ends in failure. During the whole run, the bench measures the width of every low phase and tracks the reset-hold output and the SDA driver. A second start issued mid-sequence must leave the pulse count unchanged, and a start issued after a failure must clear the old result.

// File: rtl/rec_pkg.sv
package rec_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_CHECK,
    ST_LOW,
    ST_HIGH
  } rec_state_e;
endpackage

// File: rtl/rec_sync.sv
module rec_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] pipe_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[s] <= '1;
        else if (s == 0) pipe_q[s] <= d_i;
        else pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/rec_timer.sv
module rec_timer #(
  parameter int HALF_TICKS = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int TW = $clog2(HALF_TICKS + 1);
  localparam logic [TW-1:0] LAST = TW'(HALF_TICKS - 1);

  logic [TW-1:0] cnt_q;

  assign done_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!run_i || done_o) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  p_phase_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/rec_tries.sv
module rec_tries #(
  parameter int MAX_TRIES = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic exhausted_o
);
  localparam int CW = $clog2(MAX_TRIES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_TRIES);

  logic [CW-1:0] cnt_q;

  assign exhausted_o = (cnt_q == LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  p_no_overrun_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> cnt_q < LIMIT);
endmodule

// File: rtl/i2c_bus_recover.sv
module i2c_bus_recover
  import rec_pkg::*;
#(
  parameter int HALF_TICKS  = 500,
  parameter int MAX_TRIES   = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_oe_o,
  output logic sda_oe_o,
  output logic core_rst_o,
  output logic busy_o,
  output logic recovered_o,
  output logic failed_o
);
  rec_state_e state_q, state_d;
  logic [1:0] bus_s;
  logic bus_free, t_run, t_done, try_inc, try_clr, exhausted;
  logic recovered_q, failed_q;

  rec_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({scl_i, sda_i}), .q_o(bus_s)
  );

  assign bus_free = bus_s[1] & bus_s[0];
  assign t_run    = (state_q == ST_SETTLE) || (state_q == ST_LOW) || (state_q == ST_HIGH);

  rec_timer #(.HALF_TICKS(HALF_TICKS)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(t_run), .done_o(t_done)
  );

  assign try_clr = (state_q == ST_IDLE) && start_i;
  assign try_inc = (state_q == ST_CHECK) && !bus_free && !exhausted;

  rec_tries #(.MAX_TRIES(MAX_TRIES)) u_tries (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(try_clr), .inc_i(try_inc),
    .exhausted_o(exhausted)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_SETTLE;
      ST_SETTLE: if (t_done) state_d = ST_CHECK;
      ST_CHECK:  state_d = (bus_free || exhausted) ? ST_IDLE : ST_LOW;
      ST_LOW:    if (t_done) state_d = ST_HIGH;
      ST_HIGH:   if (t_done) state_d = ST_CHECK;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      recovered_q <= 1'b0;
      failed_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (try_clr) begin
        recovered_q <= 1'b0;
        failed_q    <= 1'b0;
      end else if (state_q == ST_CHECK) begin
        if (bus_free) recovered_q <= 1'b1;
        else if (exhausted) failed_q <= 1'b1;
      end
    end
  end

  assign scl_oe_o    = (state_q == ST_LOW);
  assign sda_oe_o    = 1'b0;
  assign busy_o      = (state_q != ST_IDLE);
  assign core_rst_o  = busy_o;
  assign recovered_o = recovered_q;
  assign failed_o    = failed_q;

  p_release_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !scl_oe_o);
  p_rst_during_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_oe_o |-> core_rst_o);
  p_result_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(recovered_o && failed_o));
  p_recover_on_free_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(recovered_o) |-> $past(bus_s == 2'b11));
  p_fail_needs_budget_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(failed_o) |-> $past(exhausted));
  p_busy_ignores_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && state_q != ST_CHECK) |=> busy_o);
endmodule

// File: tb/sim_i2c_bus_recover.sv
module sim_i2c_bus_recover;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 3;
  localparam int TRIES = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic scl_oe, sda_oe, core_rst, busy, recovered, failed;

  int  n_checks = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;

  int  pulses = 0;
  int  free_after = 0;
  bit  hold_scl_mode = 1'b0;
  int  low_width = 0;
  int  low_bad = 0;
  int  rst_bad = 0;
  int  sda_bad = 0;
  bit  prev_oe = 1'b0;

  logic slave_hold;
  logic scl_line, sda_line;
  assign slave_hold = (pulses < free_after);
  assign scl_line = !scl_oe && !(hold_scl_mode && slave_hold);
  assign sda_line = !sda_oe && !(!hold_scl_mode && slave_hold);

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_bus_recover #(.HALF_TICKS(HALF), .MAX_TRIES(TRIES)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .core_rst_o(core_rst), .busy_o(busy),
    .recovered_o(recovered), .failed_o(failed)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_oe && !prev_oe) pulses++;
      if (scl_oe) low_width++;
      else if (prev_oe) begin
        if (low_width != HALF) low_bad++;
        low_width = 0;
      end
      prev_oe = scl_oe;
      if (core_rst != busy) rst_bad++;
      if (sda_oe) sda_bad++;
    end
  end

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 scl_oe", scl_oe, 0);
    check("R1 busy", busy, 0);
    check("R1 core_rst", core_rst, 0);
    check("R1 results", {recovered, failed}, 0);
    check("R1 sda_oe", sda_oe, 0);
  endtask

  task automatic t_free_bus();
    pulses = 0; free_after = 0; hold_scl_mode = 0;
    pulse_start();
    check("R2 busy after start", busy, 1);
    check("R2 lines released", scl_oe, 0);
    wait_idle();
    check("R2 recovered", recovered, 1);
    check("R2 no pulses", pulses, 0);
  endtask

  task automatic t_sda_stuck();
    pulses = 0; free_after = 3; hold_scl_mode = 0;
    pulse_start();
    repeat (5) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;  // R9 start while busy
    wait_idle();
    check("R4 recovered", recovered, 1);
    check("R4 pulse count", pulses, 3);
    check("R9 busy restart ignored", pulses, 3);
  endtask

  task automatic t_scl_held();
    pulses = 0; free_after = 2; hold_scl_mode = 1;
    pulse_start();
    wait_idle();
    check("R8 recovered", recovered, 1);
    check("R8 pulse count", pulses, 2);
    hold_scl_mode = 0;
  endtask

  task automatic t_never_free();
    pulses = 0; free_after = 1000000; hold_scl_mode = 0;
    pulse_start();
    wait_idle();
    check("R5 failed", failed, 1);
    check("R5 not recovered", recovered, 0);
    check("R5 pulse count", pulses, TRIES);
  endtask

  task automatic t_restart_clears();
    free_after = 0; pulses = 0;
    pulse_start();
    check("R9 failed cleared", failed, 0);
    check("R9 recovered cleared", recovered, 0);
    wait_idle();
    check("R9 new result", {recovered, failed}, 2'b10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_free_bus();
    t_sda_stuck();
    t_scl_held();
    t_never_free();
    t_restart_clears();
    check("R6 low phase width", low_bad, 0);
    check("R7 reset hold", rst_bad, 0);
    check("R3 sda never driven", sda_bad, 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule